// File: doc/BRIEF.md
# JTAG Clock-Edge Synchronizer with Returned Clock

This block lets a single-clock design that follows strict rising-edge D-type rules serve as a JTAG target. The externally driven test clock is never used to clock a flip-flop. It is sampled as ordinary data by a chain of flip-flops on the system clock. A delayed copy of the synchronized level is compared against the current one, and that comparison gives one-cycle enable strobes for test-clock rising and falling edges. A TAP controller and its scan chains use these strobes as clock enables.

The synchronized test-clock level is returned to the host as a retimed clock. A host that uses adaptive clocking waits for each transition of this returned clock before it issues the next test-clock edge, so the target paces the link. The serial output is retimed so that it changes only on the falling-edge enable. Serial input and mode select are captured on the rising-edge enable. A TAP-advance output repeats the rising-edge enable, so an external state machine steps once per test-clock rising edge. Both the JTAG reset and the system reset clear every register asynchronously.

The system clock must run several times faster than the test clock. Each test-clock level must stay stable for at least three system clocks.

Top module: `tck_retime_port`

## Requirements
- R1: While either reset input (active low) is asserted, rtckOut, tdoOut, tdiCap, tmsCap, tckRiseEn, tckFallEn and tapAdvance are all 0, whatever tckIn does.
- R2: A low-to-high change of tckIn makes tckRiseEn high for exactly one system clock. It becomes visible after the second system clock rising edge that follows the change.
- R3: A high-to-low change of tckIn makes tckFallEn high for exactly one system clock. It becomes visible after the second system clock rising edge that follows the change.
- R4: tckRiseEn and tckFallEn are never high together. Each test-clock half period produces exactly one strobe, and that strobe matches the direction of the change.
- R5: rtckOut follows the tckIn level with a fixed delay. It takes the new level after the third system clock rising edge that follows a tckIn change.
- R6: tdoOut loads tdoIn on the system clock edge at which tckFallEn is high. At every other edge tdoOut holds its value, and changes on tdoIn have no effect.
- R7: tdiCap and tmsCap load tdiIn and tmsIn on the system clock edge at which tckRiseEn is high. At every other edge they hold their values.
- R8: tapAdvance equals tckRiseEn in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; every register uses its rising edge |
| nReset | input | 1 | System reset, active low, asynchronous clear |
| nTrst | input | 1 | JTAG reset, active low, asynchronous clear |
| tckIn | input | 1 | Test clock from the host, sampled as data |
| tdiIn | input | 1 | Serial data input from the host |
| tmsIn | input | 1 | Mode select from the host |
| tdoIn | input | 1 | Serial data from the scan chain, to be retimed |
| rtckOut | output | 1 | Returned clock, the synchronized test-clock level |
| tdoOut | output | 1 | Retimed serial output to the host |
| tdiCap | output | 1 | Serial input captured at the rising-edge enable |
| tmsCap | output | 1 | Mode select captured at the rising-edge enable |
| tckRiseEn | output | 1 | One-cycle strobe for a test-clock rising edge |
| tckFallEn | output | 1 | One-cycle strobe for a test-clock falling edge |
| tapAdvance | output | 1 | Step enable for the TAP state machine |

## Verification
The bench changes tckIn just after a falling system-clock edge. It samples every output one half system-clock period after each later rising edge. This places an edge strobe in the second sample and the returned-clock transition in the third. tdoOut, tdiCap and tmsCap take their new values in the third sample and are checked at the end of each half period. Half periods from three to eight system clocks are swept with changing data bits. For each half period the bench counts the strobes and records the sample index of the first strobe and of the first returned-clock match. It compares these with the fixed latencies of two and three edges.

// File: rtl/tck_retime_pkg.sv
package tck_retime_pkg;

  // Strobes passed from the edge detector to the retiming datapath
  typedef struct packed {
    logic rise;
    logic fall;
  } edgeStrobes_t;

endpackage

// File: rtl/tck_retime_ctrl.sv
module tck_retime_ctrl
  import tck_retime_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         tckIn,
  output logic         tckLevel,
  output edgeStrobes_t strobes
);

  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   dlyQ;

  // Resynchronizer chain: the test clock is only data here
  for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ[g] <= 1'b0;
        else       syncQ[g] <= tckIn;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ[g] <= 1'b0;
        else       syncQ[g] <= syncQ[g-1];
      end
    end
  end

  // Delayed copy used by the edge comparison and echoed as the returned clock
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) dlyQ <= 1'b0;
    else       dlyQ <= syncQ[LAST];
  end

  always_comb begin
    strobes.rise = syncQ[LAST] & ~dlyQ;
    strobes.fall = ~syncQ[LAST] & dlyQ;
  end

  assign tckLevel = dlyQ;

endmodule

// File: rtl/tck_retime_dp.sv
module tck_retime_dp
  import tck_retime_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  edgeStrobes_t strobes,
  input  logic         tckLevel,
  input  logic         tdiIn,
  input  logic         tmsIn,
  input  logic         tdoIn,
  output logic         rtckOut,
  output logic         tdoOut,
  output logic         tdiCap,
  output logic         tmsCap
);

  // Serial output moves only with the falling-edge enable
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             tdoOut <= 1'b0;
    else if (strobes.fall) tdoOut <= tdoIn;
  end

  // Input and mode select are captured with the rising-edge enable
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tdiCap <= 1'b0;
      tmsCap <= 1'b0;
    end else if (strobes.rise) begin
      tdiCap <= tdiIn;
      tmsCap <= tmsIn;
    end
  end

  assign rtckOut = tckLevel;

endmodule

// File: rtl/tck_retime_port.sv
module tck_retime_port
  import tck_retime_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic nReset,
  input  logic nTrst,
  input  logic tckIn,
  input  logic tdiIn,
  input  logic tmsIn,
  input  logic tdoIn,
  output logic rtckOut,
  output logic tdoOut,
  output logic tdiCap,
  output logic tmsCap,
  output logic tckRiseEn,
  output logic tckFallEn,
  output logic tapAdvance
);

  logic         rstN;
  logic         tckLevel;
  edgeStrobes_t strobes;

  assign rstN = nReset & nTrst;

  tck_retime_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .tckIn    (tckIn),
    .tckLevel (tckLevel),
    .strobes  (strobes)
  );

  tck_retime_dp u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .tckLevel (tckLevel),
    .tdiIn    (tdiIn),
    .tmsIn    (tmsIn),
    .tdoIn    (tdoIn),
    .rtckOut  (rtckOut),
    .tdoOut   (tdoOut),
    .tdiCap   (tdiCap),
    .tmsCap   (tmsCap)
  );

  assign tckRiseEn  = strobes.rise;
  assign tckFallEn  = strobes.fall;
  assign tapAdvance = strobes.rise;

endmodule

// File: rtl/tck_retime_chk.sv
module tck_retime_chk (
  input logic clk,
  input logic nReset,
  input logic nTrst,
  input logic tdiIn,
  input logic tmsIn,
  input logic tdoIn,
  input logic rtckOut,
  input logic tdoOut,
  input logic tdiCap,
  input logic tmsCap,
  input logic tckRiseEn,
  input logic tckFallEn,
  input logic tapAdvance
);

  logic inReset;
  assign inReset = !(nReset && nTrst);

  // R1: outputs quiet while any reset is held
  p_reset_quiet_r1: assert property (@(posedge clk)
    inReset |-> (!rtckOut && !tdoOut && !tdiCap && !tmsCap && !tckRiseEn && !tckFallEn))
    else $error("p_reset_quiet_r1");

  // R2: rising strobe lasts one cycle
  p_rise_single_r2: assert property (@(posedge clk) disable iff (inReset)
    tckRiseEn |=> !tckRiseEn) else $error("p_rise_single_r2");

  // R3: falling strobe lasts one cycle
  p_fall_single_r3: assert property (@(posedge clk) disable iff (inReset)
    tckFallEn |=> !tckFallEn) else $error("p_fall_single_r3");

  // R4: strobes mutually exclusive
  p_strobe_excl_r4: assert property (@(posedge clk) disable iff (inReset)
    !(tckRiseEn && tckFallEn)) else $error("p_strobe_excl_r4");

  // R5: returned clock goes high right after a rising strobe, low after a falling one
  p_rtck_rise_r5: assert property (@(posedge clk) disable iff (inReset)
    tckRiseEn |=> rtckOut) else $error("p_rtck_rise_r5");
  p_rtck_fall_r5: assert property (@(posedge clk) disable iff (inReset)
    tckFallEn |=> !rtckOut) else $error("p_rtck_fall_r5");

  // R6: serial output loads at fall strobe and otherwise holds
  p_tdo_load_r6: assert property (@(posedge clk) disable iff (inReset)
    tckFallEn |=> (tdoOut == $past(tdoIn))) else $error("p_tdo_load_r6");
  p_tdo_hold_r6: assert property (@(posedge clk) disable iff (inReset)
    !tckFallEn |=> $stable(tdoOut)) else $error("p_tdo_hold_r6");

  // R7: captures load at rise strobe and otherwise hold
  p_cap_load_r7: assert property (@(posedge clk) disable iff (inReset)
    tckRiseEn |=> (tdiCap == $past(tdiIn) && tmsCap == $past(tmsIn)))
    else $error("p_cap_load_r7");
  p_cap_hold_r7: assert property (@(posedge clk) disable iff (inReset)
    !tckRiseEn |=> ($stable(tdiCap) && $stable(tmsCap))) else $error("p_cap_hold_r7");

  // R8: TAP advance never differs from the rising strobe
  p_advance_r8: assert property (@(posedge clk) disable iff (inReset)
    (tapAdvance == tckRiseEn)) else $error("p_advance_r8");

endmodule

bind tck_retime_port tck_retime_chk u_chk (.*);

// File: tb/tck_retime_port_test.sv
module tck_retime_port_test;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 200000;

  logic clk = 1'b0;
  logic nReset = 1'b0;
  logic nTrst = 1'b0;
  logic tckIn = 1'b0;
  logic tdiIn = 1'b0;
  logic tmsIn = 1'b0;
  logic tdoIn = 1'b0;
  logic rtckOut, tdoOut, tdiCap, tmsCap, tckRiseEn, tckFallEn, tapAdvance;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;

  logic expTdo = 1'b0;
  logic expTdi = 1'b0;
  logic expTms = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tck_retime_port uut (
    .clk(clk), .nReset(nReset), .nTrst(nTrst), .tckIn(tckIn),
    .tdiIn(tdiIn), .tmsIn(tmsIn), .tdoIn(tdoIn),
    .rtckOut(rtckOut), .tdoOut(tdoOut), .tdiCap(tdiCap), .tmsCap(tmsCap),
    .tckRiseEn(tckRiseEn), .tckFallEn(tckFallEn), .tapAdvance(tapAdvance)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    testsRun++;
    if (act != exp) begin
      testsFailed++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic checkQuiet(input string tag);
    check("R1", {tag, " outputs"},
          {rtckOut, tdoOut, tdiCap, tmsCap, tckRiseEn, tckFallEn, tapAdvance}, 0);
  endtask

  // One test-clock half period of len system clocks, starting at a falling clk edge
  task automatic halfPeriod(input logic newTck, input int len,
                            input logic dTdi, input logic dTms, input logic dTdo);
    int riseCnt = 0;
    int fallCnt = 0;
    int strobeAt = 0;
    int rtckAt = 0;
    int advMismatch = 0;
    tckIn = newTck;
    tdiIn = dTdi;
    tmsIn = dTms;
    tdoIn = dTdo;
    for (int i = 1; i <= len; i++) begin
      @(negedge clk);
      if (tckRiseEn) riseCnt++;
      if (tckFallEn) fallCnt++;
      if ((tckRiseEn || tckFallEn) && strobeAt == 0) strobeAt = i;
      if (rtckOut == newTck && rtckAt == 0) rtckAt = i;
      if (tapAdvance != tckRiseEn) advMismatch++;
    end
    if (newTck) begin
      expTdi = dTdi;
      expTms = dTms;
      check("R2", "rise strobe count", riseCnt, 1);
      check("R4", "fall strobes in high half", fallCnt, 0);
      check("R2", "rise strobe sample", strobeAt, 2);
      check("R7", "tdiCap", tdiCap, expTdi);
      check("R7", "tmsCap", tmsCap, expTms);
      check("R6", "tdoOut held in high half", tdoOut, expTdo);
    end else begin
      expTdo = dTdo;
      check("R3", "fall strobe count", fallCnt, 1);
      check("R4", "rise strobes in low half", riseCnt, 0);
      check("R3", "fall strobe sample", strobeAt, 2);
      check("R6", "tdoOut loaded", tdoOut, expTdo);
      check("R7", "tdiCap held in low half", tdiCap, expTdi);
      check("R7", "tmsCap held in low half", tmsCap, expTms);
    end
    check("R5", "rtck latency", rtckAt, 3);
    check("R8", "tapAdvance mismatches", advMismatch, 0);
  endtask

  task automatic resetPulse(input bit useTrst);
    @(negedge clk);
    if (useTrst) nTrst = 1'b0; else nReset = 1'b0;
    #1;
    checkQuiet("async clear");
    for (int i = 0; i < 8; i++) begin
      tckIn = ~tckIn;
      tdoIn = ~tdoIn;
      @(negedge clk);
      checkQuiet("held reset");
    end
    tckIn = 1'b0;
    @(negedge clk);
    nTrst = 1'b1;
    nReset = 1'b1;
    expTdo = 1'b0;
    expTdi = 1'b0;
    expTms = 1'b0;
    for (int i = 0; i < 4; i++) @(negedge clk);
    checkQuiet("after release, tck low");
  endtask

  initial begin : watchdog
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      testsFailed++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin : stim
    for (int i = 0; i < 4; i++) @(negedge clk);
    checkQuiet("power-on reset");
    nReset = 1'b1;
    @(negedge clk);
    checkQuiet("only JTAG reset held");
    nTrst = 1'b1;
    for (int i = 0; i < 3; i++) @(negedge clk);
    checkQuiet("idle after reset");

    for (int len = 3; len <= 8; len++) begin
      for (int k = 0; k < 4; k++) begin
        logic a, b;
        a = logic'((k + len) & 1);
        b = logic'(((k >> 1) ^ len) & 1);
        // high half: tdoIn changes but must be ignored
        halfPeriod(1'b1, len, a, b, ~expTdo);
        // low half: tdi/tms change but must be ignored
        halfPeriod(1'b0, len, ~a, ~b, a ^ b);
      end
    end

    halfPeriod(1'b1, 4, 1'b1, 1'b1, 1'b0);
    resetPulse(1'b1);
    halfPeriod(1'b1, 5, 1'b1, 1'b0, 1'b1);
    halfPeriod(1'b0, 5, 1'b0, 1'b1, 1'b1);
    resetPulse(1'b0);
    halfPeriod(1'b1, 3, 1'b0, 1'b1, 1'b1);
    halfPeriod(1'b0, 3, 1'b1, 1'b0, 1'b1);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule